// File: doc/BRIEF.md
# Field check-word generator and inserter

This block sits in a serial video transmit path, after the timing-reference detector and before the scrambler. It keeps two 16-bit CRCs for each video field. One covers the active picture only. The other covers the whole field except the timing references and the check packet itself. At each field boundary both sums are frozen into holding registers and restart from zero.

On the line that carries the error-check packet, the held sums and a status word are written into fixed payload positions of the outgoing stream. Each carried word has parity protection. A force input makes the block overwrite check data that already exists, for use when upstream content has been edited and its old check data no longer holds. The active-low enable turns insertion off. When disabled, the stream passes through with one cycle of delay.

The detector supplies one-cycle strobes on the first word of each four-word start-of-active (SAV) and end-of-active (EAV) reference. It also supplies a field-boundary strobe, the vertical-blanking bit and a flush pulse. The block tracks the horizontal position and the line number itself from these strobes.

Top module: `fieldcrc_inserter`

## Requirements
- R1: The output is the input word from the previous cycle unless a payload slot is overwritten. With `chk_en_n` high, no word is ever altered.
- R2: Both CRCs use x^16+x^12+x^6+1 and start from zero. Each word's DW bits are folded in LSB first. The word that carries `fld_strb` is the first word of the new field.
- R3: The active CRC takes every word after the four SAV reference words, up to the next EAV strobe, and only while `v_in` is 0.
- R4: The full CRC takes every word except the four words of each timing reference and the seven payload positions on the packet line.
- R5: After reset, `dout` is 0 and both held CRCs and their valid bits are 0. A held value changes only on a `fld_strb` word.
- R6: Slots 0..2 carry the active CRC and slots 3..5 carry the full CRC. In each group the first word has crc[5:0] in bits 7:2, the second has crc[11:6] in bits 7:2, and the third has crc[15:12] in bits 5:2 and the valid bit in bit 7. Slot 6 is a status word with payload 0. All other payload bits are 0. Bit 8 is the XOR of bits 7:0 and bit 9 is its inverse.
- R7: With `chk_force` low, a slot is overwritten only when the incoming bits 7:0 are all zero. Any other incoming word passes unchanged.
- R8: With `chk_force` high, every slot is overwritten whatever it carries.
- R9: A held valid bit is 1 only when its sum began at a field strobe with no reset or flush since.
- R10: `flush` clears both running CRCs and the started-at-boundary state. The word that carries the flush is not counted.
- R11: Slot k is the word at position PKT_OFS+k. Position 0 is the word after the last EAV reference word. This holds only on line PKT_LINE, where the strobe line is line 0 and each EAV adds one. Neighbouring words pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| chk_en_n | input | 1 | Insertion enable, active low |
| chk_force | input | 1 | Overwrite slots whatever they carry |
| flush | input | 1 | Clears both running CRCs |
| fld_strb | input | 1 | First word of a new field |
| sav_in | input | 1 | First word of an SAV reference |
| eav_in | input | 1 | First word of an EAV reference |
| v_in | input | 1 | Vertical blanking bit of the current line |
| din | input | DW | Incoming video word |
| dout | output | DW | Outgoing word with inserted values |

## Verification
Every output word is due exactly one clock after its input word. The bench therefore samples `dout` at the falling edge that follows the driving falling edge, and compares it with the expectation it computed when it drove that word. A held CRC computed over field N first appears in the packet of field N+1. The bench latches its own model sums on the strobe word, before it folds in that word, so that each expected packet refers to the previous field. The valid bit becomes 1 on the second boundary after a reset or flush, and the bench checks that it is 0 in the field where it should be.

// File: rtl/fieldcrc_pkg.sv
package fieldcrc_pkg;

   localparam int unsigned CRC_W = 16;
   localparam logic [CRC_W-1:0] CRC_POLY = 16'h1041;
   localparam int unsigned PKT_LEN = 7;
   localparam int unsigned SLOT_W = 3;

   typedef struct packed {
      logic             valid;
      logic [CRC_W-1:0] crc;
   } held_t;

   // Fold nb bits of d into c, least significant bit first.
   function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c,
                                                 input logic [31:0] d,
                                                 input int nb);
      logic [CRC_W-1:0] r;
      logic fb;
      r = c;
      for (int i = 0; i < 32; i++) begin
         if (i < nb) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
         end
      end
      return r;
   endfunction

   // Parity-protected 10-bit form of an 8-bit payload.
   function automatic logic [9:0] seal(input logic [7:0] p);
      return {~(^p), ^p, p};
   endfunction

   // Payload of one of the three words that carry a held sum.
   function automatic logic [7:0] chunk(input held_t h, input logic [1:0] part);
      logic [7:0] r;
      case (part)
         2'd0:    r = {h.crc[5:0], 2'b00};
         2'd1:    r = {h.crc[11:6], 2'b00};
         default: r = {h.valid, 1'b0, h.crc[15:12], 2'b00};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/fieldcrc_timing.sv
module fieldcrc_timing
   import fieldcrc_pkg::*;
#(
   parameter int unsigned HPOS_W   = 12,
   parameter int unsigned LINE_W   = 11,
   parameter int unsigned PKT_OFS  = 2,
   parameter int unsigned PKT_LINE = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sav_in,
   input  logic              eav_in,
   input  logic              fld_in,
   input  logic              v_in,
   output logic              is_trs,
   output logic              in_act,
   output logic              hole,
   output logic [SLOT_W-1:0] slot
);

   if (HPOS_W < SLOT_W || PKT_OFS + PKT_LEN >= (1 << HPOS_W)) begin : g_bad_hpos
      $error("fieldcrc_timing: packet does not fit the position counter");
   end
   if (PKT_LINE >= (1 << LINE_W)) begin : g_bad_line
      $error("fieldcrc_timing: packet line beyond line counter");
   end

   logic [1:0]        trs_left_q;
   logic              sav_kind_q;
   logic              act_q;
   logic [HPOS_W-1:0] hpos_q;
   logic [HPOS_W-1:0] rel;
   logic [LINE_W-1:0] line_q;
   logic              tail;
   logic              pkt_line;

   always_comb begin
      is_trs   = sav_in | eav_in | (trs_left_q != 2'd0);
      tail     = (trs_left_q == 2'd1);
      in_act   = act_q & ~is_trs & ~v_in;
      pkt_line = (line_q == LINE_W'(PKT_LINE));
      rel      = hpos_q - HPOS_W'(PKT_OFS);
      hole     = pkt_line & ~act_q & ~is_trs &
                 (hpos_q >= HPOS_W'(PKT_OFS)) & (rel < HPOS_W'(PKT_LEN));
      slot     = rel[SLOT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         trs_left_q <= 2'd0;
         sav_kind_q <= 1'b0;
         act_q      <= 1'b0;
         hpos_q     <= '1;
         line_q     <= '0;
      end else begin
         if (sav_in | eav_in) begin
            trs_left_q <= 2'd3;
            sav_kind_q <= sav_in;
         end else if (trs_left_q != 2'd0) begin
            trs_left_q <= trs_left_q - 2'd1;
         end
         if (eav_in)
            act_q <= 1'b0;
         else if (tail && sav_kind_q)
            act_q <= 1'b1;
         if (tail && !sav_kind_q)
            hpos_q <= '0;
         else if (hpos_q != '1)
            hpos_q <= hpos_q + 1'b1;
         if (fld_in)
            line_q <= '0;
         else if (eav_in)
            line_q <= line_q + 1'b1;
      end
   end

   p_eav_ends_act_r3 : assert property (@(posedge clk) disable iff (rst)
      eav_in |=> !act_q);
   p_trs_span_r4 : assert property (@(posedge clk) disable iff (rst)
      (sav_in || eav_in) |=> is_trs);

endmodule

// File: rtl/fieldcrc_acc.sv
module fieldcrc_acc
   import fieldcrc_pkg::*;
#(
   parameter int unsigned DW = 10
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          flush,
   input  logic          restart,
   input  logic          take,
   input  logic [DW-1:0] data,
   output held_t         held
);

   logic [CRC_W-1:0] run_q;
   logic [CRC_W-1:0] base;
   logic [CRC_W-1:0] nxt;
   logic             seen_q;

   always_comb begin
      base = restart ? '0 : run_q;
      nxt  = take ? crc_fold(base, 32'(data), int'(DW)) : base;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q  <= '0;
         seen_q <= 1'b0;
         held   <= '0;
      end else if (flush) begin
         run_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         run_q <= nxt;
         if (restart) begin
            held.crc   <= run_q;
            held.valid <= seen_q;
            seen_q     <= 1'b1;
         end
      end
   end

   p_flush_clears_r10 : assert property (@(posedge clk) disable iff (rst)
      flush |=> (run_q == '0 && !seen_q));
   p_held_stable_r5 : assert property (@(posedge clk) disable iff (rst)
      !restart |=> $stable(held));

endmodule

// File: rtl/fieldcrc_mux.sv
module fieldcrc_mux
   import fieldcrc_pkg::*;
#(
   parameter int unsigned DW = 10
) (
   input  logic [DW-1:0]     din,
   input  logic              en_n,
   input  logic              force_ins,
   input  logic              hole,
   input  logic [SLOT_W-1:0] slot,
   input  held_t             held_act,
   input  held_t             held_full,
   output logic [DW-1:0]     dout,
   output logic              hit
);

   held_t      sel;
   logic [1:0] part;
   logic [7:0] pay;

   always_comb begin
      hit = ~en_n & hole & (force_ins | (din[7:0] == 8'h00));
      if (slot < SLOT_W'(3)) begin
         sel  = held_act;
         part = slot[1:0];
      end else begin
         sel  = held_full;
         part = 2'(slot - SLOT_W'(3));
      end
      pay  = (slot == SLOT_W'(PKT_LEN - 1)) ? 8'h00 : chunk(sel, part);
      dout = hit ? DW'(seal(pay)) : din;
   end

endmodule

// File: rtl/fieldcrc_inserter.sv
module fieldcrc_inserter
   import fieldcrc_pkg::*;
#(
   parameter int unsigned DW       = 10,
   parameter int unsigned HPOS_W   = 12,
   parameter int unsigned LINE_W   = 11,
   parameter int unsigned PKT_OFS  = 2,
   parameter int unsigned PKT_LINE = 2,
   parameter bit          OUT_REG  = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          chk_en_n,
   input  logic          chk_force,
   input  logic          flush,
   input  logic          fld_strb,
   input  logic          sav_in,
   input  logic          eav_in,
   input  logic          v_in,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);

   if (DW < 10 || DW > 32) begin : g_bad_dw
      $error("fieldcrc_inserter: DW must lie in 10..32");
   end

   localparam int unsigned N_SUM = 2;   // index 0 active picture, 1 full field

   logic              tm_trs;
   logic              tm_act;
   logic              tm_hole;
   logic [SLOT_W-1:0] tm_slot;
   logic [N_SUM-1:0]  take_v;
   held_t             held_v [N_SUM];
   logic [DW-1:0]     mux_out;
   logic              mux_hit;

   fieldcrc_timing #(
      .HPOS_W(HPOS_W), .LINE_W(LINE_W), .PKT_OFS(PKT_OFS), .PKT_LINE(PKT_LINE)
   ) timing_i (
      .clk(clk), .rst(rst), .sav_in(sav_in), .eav_in(eav_in), .fld_in(fld_strb),
      .v_in(v_in), .is_trs(tm_trs), .in_act(tm_act), .hole(tm_hole), .slot(tm_slot)
   );

   assign take_v[0] = tm_act;
   assign take_v[1] = ~tm_trs & ~tm_hole;

   for (genvar k = 0; k < N_SUM; k++) begin : g_sum
      fieldcrc_acc #(.DW(DW)) acc_i (
         .clk(clk), .rst(rst), .flush(flush), .restart(fld_strb),
         .take(take_v[k]), .data(din), .held(held_v[k])
      );
   end

   fieldcrc_mux #(.DW(DW)) mux_i (
      .din(din), .en_n(chk_en_n), .force_ins(chk_force), .hole(tm_hole),
      .slot(tm_slot), .held_act(held_v[0]), .held_full(held_v[1]),
      .dout(mux_out), .hit(mux_hit)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) dout <= '0;
         else     dout <= mux_out;
      end

      p_bypass_r1 : assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(chk_en_n)) |-> dout == $past(din));
      p_seal_r6 : assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(mux_hit)) |-> (dout[8] == ^dout[7:0] && dout[9] != dout[8]));
      p_keep_r7 : assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(tm_hole && !chk_force && din[7:0] != 8'h00))
         |-> dout == $past(din));
   end else begin : g_comb
      assign dout = mux_out;
   end

endmodule

// File: tb/fieldcrc_inserter_tb_top.sv
module fieldcrc_inserter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HB = 12;      // blanking words per line
   localparam int AL = 16;      // active words per line
   localparam int NLINES = 6;
   localparam int PKT_OFS = 2;
   localparam int PKT_LINE = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic chk_en_n = 1'b0, chk_force = 1'b0, flush = 1'b0, fld_strb = 1'b0;
   logic sav_in = 1'b0, eav_in = 1'b0, v_in = 1'b0;
   logic [9:0] din = '0;
   logic [9:0] dout;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [15:0] ra = '0, rf = '0, ha = '0, hf = '0;
   bit seen = 0, hv = 0;
   bit pend = 0;
   logic [9:0] exp_q;
   string exp_tag;
   string ph = "";

   always #(CLK_PERIOD/2) clk = ~clk;

   fieldcrc_inserter dut_i (
      .clk(clk), .rst(rst), .chk_en_n(chk_en_n), .chk_force(chk_force), .flush(flush),
      .fld_strb(fld_strb), .sav_in(sav_in), .eav_in(eav_in), .v_in(v_in),
      .din(din), .dout(dout)
   );

   function automatic logic [15:0] crc10(input logic [15:0] c, input logic [9:0] d);
      logic [15:0] r = c;
      for (int i = 0; i < 10; i++) begin
         logic fb = r[15] ^ d[i];
         r = {r[14:0], 1'b0};
         if (fb) r = r ^ 16'h1041;
      end
      return r;
   endfunction

   function automatic logic [9:0] sealed(input logic [7:0] p);
      return {~(^p), ^p, p};
   endfunction

   function automatic logic [9:0] slot_word(input int k);
      logic [15:0] c = (k < 3) ? ha : hf;
      int part = k % 3;
      if (k == 6) return sealed(8'h00);
      if (part == 0) return sealed({c[5:0], 2'b00});
      if (part == 1) return sealed({c[11:6], 2'b00});
      return sealed({hv, 1'b0, c[15:12], 2'b00});
   endfunction

   task automatic chk(input logic [9:0] act, input logic [9:0] expv, input string tag);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s %s: dout=%h expected=%h", tag, ph, act, expv);
      end
   endtask

   task automatic put(input logic [9:0] d, input bit s, input bit e, input bit fs,
                      input bit fl, input bit vv, input bit trs, input bit act,
                      input int slot, input bit near);
      @(negedge clk);
      if (pend) chk(dout, exp_q, exp_tag);
      din = d; sav_in = s; eav_in = e; fld_strb = fs; flush = fl; v_in = vv;
      if (slot >= 0 && !chk_en_n && (chk_force || d[7:0] == 8'h00)) begin
         exp_q = slot_word(slot);
         exp_tag = (slot < 3) ? "R2 R3 R6" : (slot < 6) ? "R2 R4 R6" : "R6";
         if (chk_force) exp_tag = {exp_tag, " R8"};
      end else begin
         exp_q = d;
         exp_tag = chk_en_n ? "R1" : (slot >= 0) ? "R7" : near ? "R11" : "R1";
      end
      if (fl) begin
         ra = '0; rf = '0; seen = 0;
      end else begin
         if (fs) begin ha = ra; hf = rf; hv = seen; seen = 1; ra = '0; rf = '0; end
         if (act) ra = crc10(ra, d);
         if (!trs && slot < 0) rf = crc10(rf, d);
      end
      pend = 1;
   endtask

   task automatic send_line(input int ln, input bit strobe, input bit filled, input int fl_idx);
      bit vv = (ln < 3);
      bit pl = (ln == PKT_LINE);
      put(10'h3FF, 0, 1, strobe, 0, vv, 1, 0, -1, 0);
      put(10'h000, 0, 0, 0, 0, vv, 1, 0, -1, 0);
      put(10'h000, 0, 0, 0, 0, vv, 1, 0, -1, 0);
      put(10'($urandom), 0, 0, 0, 0, vv, 1, 0, -1, 0);
      for (int h = 0; h < HB; h++) begin
         bit in_pkt = pl && h >= PKT_OFS && h < PKT_OFS + 7;
         logic [9:0] d = 10'($urandom);
         if (in_pkt) d = filled ? {d[9:8], d[7:1], 1'b1} : {d[9:8], 8'h00};
         else if (pl) d = {2'b00, d[7:1], 1'b1};
         put(d, 0, 0, 0, 0, vv, 0, 0, in_pkt ? h - PKT_OFS : -1, pl);
      end
      put(10'h3FF, 1, 0, 0, 0, vv, 1, 0, -1, 0);
      put(10'h000, 0, 0, 0, 0, vv, 1, 0, -1, 0);
      put(10'h000, 0, 0, 0, 0, vv, 1, 0, -1, 0);
      put(10'($urandom), 0, 0, 0, 0, vv, 1, 0, -1, 0);
      for (int a = 0; a < AL; a++)
         put(10'($urandom), 0, 0, 0, a == fl_idx, vv, 0, !vv, -1, 0);
   endtask

   task automatic send_field(input bit filled, input bit fl);
      for (int ln = 0; ln < NLINES; ln++)
         send_line(ln, ln == 0, filled, (fl && ln == 4) ? 5 : -1);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      chk(dout, 10'h000, "R5");          // reset state
      @(negedge clk);
      rst = 1'b0;
      ph = "R5 field after reset";       // held zero, valid zero
      send_field(0, 0);
      ph = "R9 first complete field";
      send_field(0, 0);
      ph = "R7 filled slots kept";
      send_field(1, 0);
      ph = "R8 forced overwrite";
      chk_force = 1'b1;
      send_field(1, 0);
      chk_force = 1'b0;
      ph = "R1 disabled";
      chk_en_n = 1'b1;
      send_field(0, 0);
      chk_en_n = 1'b0;
      ph = "R10 flush in this field";
      send_field(0, 1);
      ph = "R10 R9 partial after flush";
      send_field(0, 0);
      ph = "R9 valid again";
      send_field(0, 0);
      for (int f = 0; f < 5; f++) begin
         ph = "R2 random field";
         chk_force = 1'($urandom);
         send_field(1'($urandom), 0);
      end
      @(negedge clk);
      if (pend) chk(dout, exp_q, exp_tag);
      summary();
   end
endmodule